// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block sits beside a DRAM command scheduler. For every bank it records the earliest clock cycle at which that bank may next take a column command (read or write), a precharge, or an activate. The values are updated from the stream of issued commands. The scheduler reads three flag vectors, one bit per bank, and uses them to decide which commands are legal in the current cycle. All timing limits are parameters counted in clock cycles. Their defaults are derived from nanosecond figures by rounding up at a 1.25 ns clock.

A free-running cycle counter provides the time base. It is brought out so that the scheduler can report when the data of a write finishes. That write-completion cycle travels with the write command, and the write recovery bound is counted from it. A read, by contrast, bounds the precharge from the cycle the read itself was issued.

Every new precharge bound is merged by maximum with the bank's existing bound, so an earlier, longer constraint is never shortened. A command that arrives while its flag is low raises a sticky violation flag and records the bank it targeted.

Top module: `dram_bank_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the cycle counter reads 0, every bit of `col_ok`, `pre_ok` and `act_ok` is 1, and `violation` is 0.
- R2: Once out of reset, `cycle_now` increases by exactly one each clock.
- R3: A read (`cmd_type`=1) or write (`cmd_type`=2) issued in cycle t clears that bank's `col_ok` from cycle t+1. The bit returns to 1 when `cycle_now` reaches t+T_BURST (default 4).
- R4: A read issued in cycle t keeps that bank's `pre_ok` low until `cycle_now` reaches t+T_RTP (default 6).
- R5: A write issued with completion cycle `wr_end` keeps that bank's `pre_ok` low until `cycle_now` reaches `wr_end`+T_WR (default 12).
- R6: An activate (`cmd_type`=0) issued in cycle t keeps that bank's `pre_ok` low until `cycle_now` reaches t+T_RAS (default 28).
- R7: A precharge bound is only ever raised. A later command whose own bound is earlier leaves the existing bound in place.
- R8: A precharge (`cmd_type`=3) issued in cycle t keeps that bank's `act_ok` low until `cycle_now` reaches t+T_RP (default 11).
- R9: A command changes the flags of the addressed bank only (bank index `cmd_bank`).
- R10: A command whose governing flag is low for its bank raises `violation` on the next cycle. The governing flag is `col_ok` for a read or write, `pre_ok` for a precharge, and `act_ok` for an activate. The flag then stays high until reset. `viol_bank` holds the bank of the first such command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BANK_W | Target bank of the command |
| wr_end | input | CNT_W | Cycle at which the write data finishes (writes only) |
| cycle_now | output | CNT_W | Free-running cycle count |
| col_ok | output | NUM_BANKS | Column command allowed, per bank |
| pre_ok | output | NUM_BANKS | Precharge allowed, per bank |
| act_ok | output | NUM_BANKS | Activate allowed, per bank |
| violation | output | 1 | Sticky: an illegal command was seen |
| viol_bank | output | BANK_W | Bank of the first illegal command |

## Verification
The assertions assume that `cycle_now` does not wrap during a run. They also assume that every timing parameter is at least 2, so a freshly issued command always blocks its bank on the following cycle. The stimulus stays well below the counter limit and uses the default timings. It gives each write a completion cycle a few clocks after its issue, which keeps the recovery bound ahead of the current cycle. Illegal commands are issued only in the final phase, so the earlier flag checks run with `violation` known to be low.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // round a picosecond figure up to whole clocks
  function automatic int unsigned ps_to_clk(input int unsigned ps, input int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned later_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // precharge bound created by one command; 0 means "no new bound"
  function automatic int unsigned pre_bound(input cmd_e kind, input int unsigned now,
                                            input int unsigned wr_done,
                                            input int unsigned t_rtp, input int unsigned t_wr,
                                            input int unsigned t_ras);
    case (kind)
      CMD_RD:  return now + t_rtp;
      CMD_WR:  return wr_done + t_wr;
      CMD_ACT: return now + t_ras;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/dtt_cycle_counter.sv
module dtt_cycle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cycle_now
);

  always_ff @(posedge clk) begin
    if (!rst_n) cycle_now <= '0;
    else        cycle_now <= cycle_now + 1'b1;
  end

  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cycle_now == $past(cycle_now) + 1'b1);

endmodule

// File: rtl/dtt_bank_timer.sv
module dtt_bank_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int T_BURST = 4,
  parameter int T_RTP   = 6,
  parameter int T_WR    = 12,
  parameter int T_RAS   = 28,
  parameter int T_RP    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_now,
  input  logic             hit,
  input  cmd_e             kind,
  input  logic [CNT_W-1:0] wr_done,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             act_ok
);

  logic [CNT_W-1:0] col_at, pre_at, act_at;
  logic [CNT_W-1:0] pre_new, col_new, act_new;
  logic             is_col, is_pre, is_act;

  assign is_col = hit && (kind == CMD_RD || kind == CMD_WR);
  assign is_pre = hit && (kind == CMD_PRE);
  assign is_act = hit && (kind == CMD_ACT);

  assign col_new = CNT_W'(int'(cycle_now) + T_BURST);
  assign act_new = CNT_W'(later_of(int'(act_at), int'(cycle_now) + T_RP));
  assign pre_new = CNT_W'(later_of(int'(pre_at),
                     pre_bound(kind, int'(cycle_now), int'(wr_done), T_RTP, T_WR, T_RAS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_at <= '0;
      pre_at <= '0;
      act_at <= '0;
    end else if (hit) begin
      if (is_col) col_at <= col_new;
      if (!is_pre) pre_at <= pre_new;
      if (is_pre) act_at <= act_new;
    end
  end

  assign col_ok = (cycle_now >= col_at);
  assign pre_ok = (cycle_now >= pre_at);
  assign act_ok = (cycle_now >= act_at);

  assert_col_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && T_BURST > 1) |=> !col_ok);
  assert_rd_pre_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == CMD_RD && T_RTP > 1) |=> !pre_ok);
  assert_act_pre_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && T_RAS > 1) |=> !pre_ok);
  assert_pre_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pre_at >= $past(pre_at));
  assert_act_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && T_RP > 1) |=> !act_ok);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(col_at) && $stable(pre_at) && $stable(act_at)));

endmodule

// File: rtl/dtt_violation_monitor.sv
module dtt_violation_monitor
  import dtt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  cmd_e                 kind,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] col_ok,
  input  logic [NUM_BANKS-1:0] pre_ok,
  input  logic [NUM_BANKS-1:0] act_ok,
  output logic                 violation,
  output logic [BANK_W-1:0]    viol_bank
);

  logic permitted;
  logic illegal_cmd;

  always_comb begin
    case (kind)
      CMD_RD, CMD_WR: permitted = col_ok[bank];
      CMD_PRE:        permitted = pre_ok[bank];
      default:        permitted = act_ok[bank];
    endcase
  end

  assign illegal_cmd = cmd_valid && !permitted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation <= 1'b0;
      viol_bank <= '0;
    end else if (illegal_cmd && !violation) begin
      violation <= 1'b1;
      viol_bank <= bank;
    end
  end

  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> (violation && $stable(viol_bank)));
  assert_viol_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |=> violation);

endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dtt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16,
  parameter int CLK_PS    = 1250,
  parameter int T_BURST   = 4,
  parameter int T_RTP     = int'(ps_to_clk(7500, CLK_PS)),
  parameter int T_WR      = int'(ps_to_clk(15000, CLK_PS)),
  parameter int T_RAS     = int'(ps_to_clk(35000, CLK_PS)),
  parameter int T_RP      = int'(ps_to_clk(13750, CLK_PS)),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_type,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [CNT_W-1:0]     wr_end,
  output logic [CNT_W-1:0]     cycle_now,
  output logic [NUM_BANKS-1:0] col_ok,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic                 violation,
  output logic [BANK_W-1:0]    viol_bank
);

  cmd_e                 kind;
  logic [NUM_BANKS-1:0] bank_hit;

  assign kind = cmd_e'(cmd_type);

  dtt_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = cmd_valid && (cmd_bank == BANK_W'(b));
    dtt_bank_timer #(
      .CNT_W(CNT_W), .T_BURST(T_BURST), .T_RTP(T_RTP), .T_WR(T_WR),
      .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_timer (
      .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now), .hit(bank_hit[b]),
      .kind(kind), .wr_done(wr_end),
      .col_ok(col_ok[b]), .pre_ok(pre_ok[b]), .act_ok(act_ok[b])
    );
  end

  dtt_violation_monitor #(.NUM_BANKS(NUM_BANKS)) u_viol (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .kind(kind), .bank(cmd_bank),
    .col_ok(col_ok), .pre_ok(pre_ok), .act_ok(act_ok),
    .violation(violation), .viol_bank(viol_bank)
  );

  assert_one_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (&col_ok && &pre_ok && &act_ok && !violation));

endmodule

// File: tb/dram_bank_timer_tb.sv
module dram_bank_timer_tb;

  localparam int NB = 4;
  localparam int CW = 16;
  localparam int TB_BURST = 4, TB_RTP = 6, TB_WR = 12, TB_RAS = 28, TB_RP = 11;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_valid = 0;
  logic [1:0]    cmd_type = 0;
  logic [1:0]    cmd_bank = 0;
  logic [CW-1:0] wr_end = 0;
  logic [CW-1:0] cycle_now;
  logic [NB-1:0] col_ok, pre_ok, act_ok;
  logic          violation;
  logic [1:0]    viol_bank;

  dram_bank_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .wr_end(wr_end), .cycle_now(cycle_now),
    .col_ok(col_ok), .pre_ok(pre_ok), .act_ok(act_ok),
    .violation(violation), .viol_bank(viol_bank)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    int            cyc;
    logic [NB-1:0] col, pre, act;
    logic          viol;
    logic [1:0]    vb;
    string         pre_tag;
  } exp_t;
  exp_t sb_q[$];

  // reference bookkeeping, restated from the requirements
  int    m_cyc;
  int    m_col[NB], m_pre[NB], m_act[NB];
  logic  m_viol;
  logic [1:0] m_vb;
  string cur_tag = "R1";

  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", req, m_cyc, act_v, exp_v);
    end
  endtask

  // driver: issue (or idle) for one cycle, update reference, queue the expectation
  task automatic step(input bit v, input int kind, input int bank, input int wend);
    exp_t e;
    bit   allowed;
    @(negedge clk);
    cmd_valid = v; cmd_type = 2'(kind); cmd_bank = 2'(bank); wr_end = CW'(wend);
    if (v) begin
      case (kind)
        1, 2:    allowed = m_cyc >= m_col[bank];
        3:       allowed = m_cyc >= m_pre[bank];
        default: allowed = m_cyc >= m_act[bank];
      endcase
      if (!allowed && !m_viol) begin m_viol = 1; m_vb = 2'(bank); end
      case (kind)
        0: m_pre[bank] = mx(m_pre[bank], m_cyc + TB_RAS);
        1: begin m_col[bank] = m_cyc + TB_BURST; m_pre[bank] = mx(m_pre[bank], m_cyc + TB_RTP); end
        2: begin m_col[bank] = m_cyc + TB_BURST; m_pre[bank] = mx(m_pre[bank], wend + TB_WR); end
        default: m_act[bank] = mx(m_act[bank], m_cyc + TB_RP);
      endcase
    end
    m_cyc++;
    @(posedge clk); #1;
    cmd_valid = 0;
    e.cyc = m_cyc;
    for (int b = 0; b < NB; b++) begin
      e.col[b] = m_cyc >= m_col[b];
      e.pre[b] = m_cyc >= m_pre[b];
      e.act[b] = m_cyc >= m_act[b];
    end
    e.viol = m_viol; e.vb = m_vb; e.pre_tag = cur_tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  // monitor: compare design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check("R2 cycle", int'(cycle_now), e.cyc);
        check("R3 col_ok", int'(col_ok), int'(e.col));
        check({e.pre_tag, " pre_ok"}, int'(pre_ok), int'(e.pre));
        check("R8 act_ok", int'(act_ok), int'(e.act));
        check("R10 violation", int'(violation), int'(e.viol));
        if (e.viol) check("R10 viol_bank", int'(viol_bank), int'(e.vb));
      end
    end
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_cyc = 0; m_viol = 0; m_vb = 0;
    for (int b = 0; b < NB; b++) begin m_col[b] = 0; m_pre[b] = 0; m_act[b] = 0; end
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 cycle", int'(cycle_now), 0);
    check("R1 col_ok", int'(col_ok), 4'hF);
    check("R1 pre_ok", int'(pre_ok), 4'hF);
    check("R1 act_ok", int'(act_ok), 4'hF);
    check("R1 violation", int'(violation), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 after release", int'(pre_ok & col_ok & act_ok), 4'hF);
    m_cyc = 1;
    // R6: activate bank 0 holds its precharge; R9: other banks untouched
    cur_tag = "R6"; step(1, 0, 0, 0); idle(30);
    // R3 and R4: read on bank 0
    cur_tag = "R4"; step(1, 1, 0, 0); idle(8);
    // R5: write on bank 1, data done a few cycles later
    cur_tag = "R5"; step(1, 2, 1, m_cyc + 7); idle(22);
    // R7: activate bank 2, then a read whose own bound is earlier
    cur_tag = "R7"; step(1, 0, 2, 0); idle(2); step(1, 1, 2, 0); idle(30);
    // R8: precharge bank 0, wait out T_RP
    cur_tag = "R8"; step(1, 3, 0, 0); idle(13);
    // R9: commands on bank 3 only, others must hold
    cur_tag = "R9"; step(1, 0, 3, 0); idle(4); step(1, 2, 3, m_cyc + 3); idle(4);
    // R10: illegal read back-to-back on bank 3, then illegal precharge on bank 1
    cur_tag = "R10"; step(1, 1, 3, 0); step(1, 1, 3, 0); idle(2);
    step(1, 0, 1, 0); step(1, 3, 1, 0); idle(3);
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule